// File: doc/BRIEF.md
# Leaf Delay-Code Loader

This block sits at one leaf of a buffered clock tree and holds the code that sets the leaf's tuning capacitors. It listens to the serial data line of the two-wire tuning bus. It also watches a match strobe from the leaf's last-level address decoder. When that strobe rises, a one-cycle start pulse clears the block's shift register and arms it. The next seven data bits are then taken in, most significant first. After the seventh bit the register locks, and the complete code is copied to the capacitor-enable outputs in a single step. The bank therefore never sees a partial code.

Once locked, the block ignores all further bus traffic until the match strobe falls and rises again. Traffic meant for other leaves, which leaves this leaf's strobe low, cannot change the stored code. A global reset sets the code to zero, which selects the smallest added delay. Output bit k enables the capacitor of weight 2^k.

The serial line has no valid/ready pair. Every bus clock carries one bit and the block cannot push back. The bus master alone is responsible for the timing of the sequence.

Top module: `ldr_cap_code_loader`

## Requirements
- R1: While `rst_n` is low, `cap_en_o` is all zeros. It stays zero after reset until a complete code has been loaded.
- R2: A capture starts only on a low-to-high transition of `hit_i`. Holding `hit_i` high does not start another capture, and a locked code stays unchanged for as long as `hit_i` stays high.
- R3: Let E0 be the clock edge that first samples `hit_i` high. The code bits are sampled at edges E0+2 through E0+8, most significant bit first. `cap_en_o` shows the new code right after edge E0+8.
- R4: `cap_en_o` keeps its previous value while a capture is in progress. In particular it does not change after the sixth bit has been sampled.
- R5: After the seventh bit the block locks. Any further activity on `sdata_i` leaves `cap_en_o` unchanged until the next rising edge of `hit_i`.
- R6: When `hit_i` stays low, because another leaf is being addressed, `cap_en_o` is unchanged whatever appears on `sdata_i`.
- R7: A rising edge of `hit_i` during a capture restarts it. The bits already taken in are discarded, and the code delivered is the one framed by the new edge.
- R8: `cap_en_o[k]` is bit k of the loaded code and enables a capacitor of weight 2^k. Read as an unsigned number, `cap_en_o` equals the value that was shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bus clock |
| rst_n | input | 1 | Global power-on reset, active low, asynchronous |
| hit_i | input | 1 | Match strobe from this leaf's last-level address decoder |
| sdata_i | input | 1 | Serial data line, one bit per clock |
| cap_en_o | output | CODE_W (7) | Capacitor enables; bit k has weight 2^k |

## Verification
Edge E0 samples the strobe high. The start pulse appears after E0 and clears the register at E0+1. Data bits are due at E0+2 through E0+8, and the new code appears right after E0+8. The bench drives each bit on the falling edge before the rising edge that samples it. It checks the output on the falling edge after E0+8, and once more on the falling edge just before the last bit, where the old code must still be present. The lock, held-strobe and no-strobe cases drive many extra bus cycles and then compare the output with the code loaded before them.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int unsigned DEF_CODE_W = 7;

  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ldr_edge_pulse.sv
module ldr_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      pulse_o <= lvl_i & ~lvl_q;
    end
  end
endmodule

// File: rtl/ldr_shifter.sv
module ldr_shifter #(
  parameter int unsigned CODE_W = ldr_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] word_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned CW = ldr_pkg::cnt_w(CODE_W);
  localparam logic [CW-1:0] LAST = CW'(CODE_W - 1);

  logic [CODE_W-1:0] sh;
  logic [CW-1:0]     cnt;

  assign word_o = {sh[CODE_W-2:0], sdata_i};
  assign done_o = busy_o && !start_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (start_i) begin
      sh     <= '0;
      cnt    <= '0;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      sh  <= word_o;
      cnt <= cnt + CW'(1);
      if (done_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ldr_code_reg.sv
module ldr_code_reg #(
  parameter int unsigned CODE_W = ldr_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] d_i,
  output logic [CODE_W-1:0] q_o
);
  for (genvar k = 0; k < CODE_W; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o[k] <= 1'b0;
      else if (load_i) q_o[k] <= d_i[k];
    end
  end
endmodule

// File: rtl/ldr_cap_code_loader.sv
module ldr_cap_code_loader #(
  parameter int unsigned CODE_W = ldr_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] cap_en_o
);
  logic              start_pulse;
  logic              word_done;
  logic              capturing;
  logic [CODE_W-1:0] word;

  ldr_edge_pulse u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (hit_i),
    .pulse_o(start_pulse)
  );

  ldr_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_pulse),
    .sdata_i(sdata_i),
    .word_o (word),
    .done_o (word_done),
    .busy_o (capturing)
  );

  ldr_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(word_done),
    .d_i   (word),
    .q_o   (cap_en_o)
  );
endmodule

// File: rtl/ldr_cap_code_loader_chk.sv
module ldr_cap_code_loader_chk #(
  parameter int unsigned CODE_W = ldr_pkg::DEF_CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit_i,
  input logic              start_pulse,
  input logic              word_done,
  input logic              capturing,
  input logic [CODE_W-1:0] cap_en_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> cap_en_o == '0);

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R2
  pulse_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(hit_i));

  // R7
  capture_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capturing) |-> $past(start_pulse));

  // R4
  whole_code_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_en_o) |-> $past(word_done));

  // R5
  lock_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !capturing);
endmodule

bind ldr_cap_code_loader ldr_cap_code_loader_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_i      (hit_i),
  .start_pulse(start_pulse),
  .word_done  (word_done),
  .capturing  (capturing),
  .cap_en_o   (cap_en_o)
);

// File: tb/ldr_cap_code_loader_tb.sv
module ldr_cap_code_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit = 1'b0;
  logic       sdata = 1'b0;
  logic [6:0] cap_en;
  int         n_run = 0;
  int         n_fail = 0;
  int         cycles = 0;

  always #10 clk = ~clk;

  ldr_cap_code_loader u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .sdata_i (sdata),
    .cap_en_o(cap_en)
  );

  task automatic check(input string req, input logic [6:0] exp);
    n_run++;
    if (cap_en !== exp) begin
      n_fail++;
      $display("FAIL %s: cap_en=%0d expected=%0d", req, cap_en, exp);
    end
  endtask

  // Frame one code: strobe rises at N0, bits at E0+2..E0+8, check after E0+8
  task automatic load(input int code, input bit hold, input bit chk_part,
                      input logic [6:0] prev);
    @(negedge clk) hit = 1'b1;
    @(negedge clk) if (!hold) hit = 1'b0;
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      if (j == 6 && chk_part) check("R4 partial code held", prev);
      sdata = code[6-j];
    end
    @(negedge clk);
  endtask

  task automatic idle_bits(input int n, input int seed);
    for (int j = 0; j < n; j++) begin
      @(negedge clk) sdata = ((seed >> (j % 7)) ^ j) & 1;
    end
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        n_run++;
        $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [6:0] cur;
    repeat (3) @(negedge clk);
    check("R1 reset zero", 7'd0);
    rst_n = 1'b1;
    idle_bits(10, 7'h55);
    check("R1 zero until loaded", 7'd0);

    cur = 7'd0;
    // R3 R8: every code value, MSB first, bit k weight 2^k
    for (int c = 0; c < 128; c++) begin
      load(c, 1'b0, 1'b1, cur);
      check("R3 R8 loaded code", 7'(c));
      cur = 7'(c);
    end

    // R5: locked against further traffic
    idle_bits(25, 7'h2B);
    check("R5 locked after seven bits", cur);

    // R6: another leaf addressed, strobe low
    idle_bits(40, 7'h1D);
    check("R6 no strobe no change", cur);

    // R2: strobe held high does not restart
    load(7'h5A, 1'b1, 1'b1, cur);
    check("R2 load with held strobe", 7'h5A);
    cur = 7'h5A;
    idle_bits(15, 7'h33);
    check("R2 held strobe no restart", cur);
    @(negedge clk) hit = 1'b0;
    idle_bits(5, 7'h7F);
    check("R2 strobe release no change", cur);

    // R7: restart mid-capture discards partial bits
    @(negedge clk) hit = 1'b1;
    @(negedge clk) hit = 1'b0;
    idle_bits(3, 7'h7F);
    check("R7 partial not applied", cur);
    load(7'h13, 1'b0, 1'b1, cur);
    check("R7 restarted code", 7'h13);
    cur = 7'h13;

    // R1: reset mid-operation clears code
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears code", 7'd0);
    rst_n = 1'b1;
    load(7'h41, 1'b0, 1'b1, 7'd0);
    check("R3 load after reset", 7'h41);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule